// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block carries a data word across two ports in both directions at once. Port A feeds port B and port B feeds port A. Each direction has its own storage path and its own four controls:

- a pass-through enable;
- a capture strobe;
- an active-low strobe qualifier;
- an active-low drive enable.

A path works in one of three ways. In pass-through the output follows the input within the same cycle. In hold the output keeps its stored word. In capture the input is stored when the strobe rises.

All logic runs on one system clock. The capture strobe of each direction is a level input that is sampled on that clock. A rising strobe is a cycle in which the strobe is high and its previous sampled level was low. The strobe history counts as low after reset.

Each driven port is a data word plus an output-valid flag. With the drive enable high, output-valid is low and the data reads as zero. Each input carries an input-valid flag that marks the input as driven. An optional keeper (parameter `HOLD_EN`) stands in for an input while that input is not driven, supplying the last word seen while it was driven.

The ports carry no ready signal and the block applies no back-pressure. A valid word is consumed as it arrives, and a consumer that must stall has to hold its drive enable high.

Top module: `regbus_xcvr`

## Requirements
- R1: With a direction's pass enable high, its output data equals that direction's effective input in the same cycle.
- R2: With pass enable low and no qualified rising strobe at a clock edge, the stored word is unchanged across that edge.
- R3: With pass enable low, a rising strobe sampled while the qualifier is low (0) stores the effective input. This happens once per rise, and a strobe held high stores nothing further.
- R4: While the qualifier is high (1), rising strobes leave the stored word unchanged.
- R5: When pass enable falls, the stored word is the effective input sampled at the last clock edge at which pass enable was high.
- R6: Drive enable low (0) gives output-valid 1 with the path value. Drive enable high (1) gives output-valid 0 and all-zero data.
- R7: The two directions are fully independent: the controls and data of one never change the other's output.
- R8: With `HOLD_EN`=1 the effective input is the live input while input-valid is 1. While input-valid is 0, it is the last word sampled with input-valid 1.
- R9: A synchronous reset (active high) clears both stored words, both keepers and both strobe histories to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Word arriving at port A |
| a_in_vld | input | 1 | Port A input is driven |
| b_in | input | WIDTH | Word arriving at port B |
| b_in_vld | input | 1 | Port B input is driven |
| ab_le | input | 1 | A-to-B pass enable |
| ab_strobe | input | 1 | A-to-B capture strobe level |
| ab_ce_n | input | 1 | A-to-B strobe qualifier, active low |
| ab_oe_n | input | 1 | Port B drive enable, active low |
| ba_le | input | 1 | B-to-A pass enable |
| ba_strobe | input | 1 | B-to-A capture strobe level |
| ba_ce_n | input | 1 | B-to-A strobe qualifier, active low |
| ba_oe_n | input | 1 | Port A drive enable, active low |
| a_out | output | WIDTH | Word driven onto port A |
| a_out_vld | output | 1 | Port A is driven |
| b_out | output | WIDTH | Word driven onto port B |
| b_out_vld | output | 1 | Port B is driven |

## Verification
The bench builds the block with `WIDTH`=12 and `HOLD_EN`=1. The narrow word makes the all-ones and top-bit patterns cheap to reach in the random phase. The keeper being present puts the undriven-input behaviour of R8 within reach. Directed phases cover the following cases:

- held strobes;
- strobes suppressed by the qualifier;
- pass enable falling;
- both directions being driven at once with conflicting controls.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  typedef enum logic [1:0] {
    PM_HOLD = 2'd0,
    PM_PASS = 2'd1,
    PM_CAPT = 2'd2
  } path_mode_e;
endpackage

// File: rtl/xcvr_keeper.sv
`timescale 1ns/1ps
module xcvr_keeper #(
  parameter int WIDTH   = 18,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic             din_vld,
  output logic [WIDTH-1:0] dout
);
  generate
    if (HOLD_EN) begin : g_keep
      logic [WIDTH-1:0] last_q;
      always_ff @(posedge clk) begin
        if (rst)          last_q <= '0;
        else if (din_vld) last_q <= din;
      end
      assign dout = din_vld ? din : last_q;
    end else begin : g_bare
      logic unused_ok;
      assign unused_ok = ^{clk, rst, din_vld};
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/xcvr_store.sv
`timescale 1ns/1ps
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  input  logic             le,
  input  logic             stb,
  input  logic             ce_n,
  output logic [WIDTH-1:0] q,
  output logic             pass
);
  logic       stb_q;
  logic       stb_rise;
  path_mode_e mode;

  assign stb_rise = stb & ~stb_q;

  always_comb begin
    if (le)                   mode = PM_PASS;
    else if (stb_rise & ~ce_n) mode = PM_CAPT;
    else                      mode = PM_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= stb;
      case (mode)
        PM_PASS, PM_CAPT: q <= d;
        default:          q <= q;
      endcase
    end
  end

  assign pass = (mode == PM_PASS);
endmodule

// File: rtl/xcvr_drive.sv
`timescale 1ns/1ps
module xcvr_drive #(
  parameter int WIDTH = 18
) (
  input  logic [WIDTH-1:0] d,
  input  logic             oe_n,
  output logic [WIDTH-1:0] o,
  output logic             o_vld
);
  assign o_vld = ~oe_n;
  assign o     = oe_n ? '0 : d;
endmodule

// File: rtl/xcvr_path.sv
`timescale 1ns/1ps
module xcvr_path #(
  parameter int WIDTH   = 18,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] src,
  input  logic             src_vld,
  input  logic             le,
  input  logic             stb,
  input  logic             ce_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] dst,
  output logic             dst_vld
);
  logic [WIDTH-1:0] eff;
  logic [WIDTH-1:0] stored;
  logic [WIDTH-1:0] view;
  logic             pass;

  xcvr_keeper #(.WIDTH(WIDTH), .HOLD_EN(HOLD_EN)) u_keep (
    .clk(clk), .rst(rst), .din(src), .din_vld(src_vld), .dout(eff)
  );

  xcvr_store #(.WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst), .d(eff), .le(le), .stb(stb), .ce_n(ce_n),
    .q(stored), .pass(pass)
  );

  assign view = pass ? eff : stored;

  xcvr_drive #(.WIDTH(WIDTH)) u_drv (
    .d(view), .oe_n(oe_n), .o(dst), .o_vld(dst_vld)
  );
endmodule

// File: rtl/regbus_xcvr.sv
`timescale 1ns/1ps
module regbus_xcvr #(
  parameter int WIDTH   = 18,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic             a_in_vld,
  input  logic [WIDTH-1:0] b_in,
  input  logic             b_in_vld,
  input  logic             ab_le,
  input  logic             ab_strobe,
  input  logic             ab_ce_n,
  input  logic             ab_oe_n,
  input  logic             ba_le,
  input  logic             ba_strobe,
  input  logic             ba_ce_n,
  input  logic             ba_oe_n,
  output logic [WIDTH-1:0] a_out,
  output logic             a_out_vld,
  output logic [WIDTH-1:0] b_out,
  output logic             b_out_vld
);
  localparam int NDIR = 2;

  logic [NDIR-1:0][WIDTH-1:0] src_w;
  logic [NDIR-1:0][WIDTH-1:0] dst_w;
  logic [NDIR-1:0]            src_vld_w, le_w, stb_w, ce_n_w, oe_n_w, dst_vld_w;

  // direction 0 = A to B, direction 1 = B to A
  assign src_w     = {b_in, a_in};
  assign src_vld_w = {b_in_vld, a_in_vld};
  assign le_w      = {ba_le, ab_le};
  assign stb_w     = {ba_strobe, ab_strobe};
  assign ce_n_w    = {ba_ce_n, ab_ce_n};
  assign oe_n_w    = {ba_oe_n, ab_oe_n};

  generate
    for (genvar g = 0; g < NDIR; g++) begin : g_dir
      xcvr_path #(.WIDTH(WIDTH), .HOLD_EN(HOLD_EN)) u_path (
        .clk(clk), .rst(rst),
        .src(src_w[g]), .src_vld(src_vld_w[g]),
        .le(le_w[g]), .stb(stb_w[g]), .ce_n(ce_n_w[g]), .oe_n(oe_n_w[g]),
        .dst(dst_w[g]), .dst_vld(dst_vld_w[g])
      );
    end
  endgenerate

  assign b_out     = dst_w[0];
  assign b_out_vld = dst_vld_w[0];
  assign a_out     = dst_w[1];
  assign a_out_vld = dst_vld_w[1];
endmodule

// File: rtl/xcvr_chk.sv
`timescale 1ns/1ps
module xcvr_chk #(
  parameter int WIDTH   = 18,
  parameter bit HOLD_EN = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic             a_in_vld,
  input logic [WIDTH-1:0] b_in,
  input logic             b_in_vld,
  input logic             ab_le,
  input logic             ab_strobe,
  input logic             ab_ce_n,
  input logic             ab_oe_n,
  input logic             ba_le,
  input logic             ba_oe_n,
  input logic [WIDTH-1:0] a_out,
  input logic             a_out_vld,
  input logic [WIDTH-1:0] b_out,
  input logic             b_out_vld
);
  assert_ab_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (ab_le && a_in_vld && !ab_oe_n) |-> (b_out == a_in));

  assert_ab_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && !ab_oe_n && $past(!rst && !ab_le && !ab_strobe && !ab_oe_n))
      |-> $stable(b_out));

  assert_ab_capt_R3: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && !ab_oe_n && $past(!rst && !ab_le && ab_strobe && !ab_ce_n && a_in_vld)
      && !$past(ab_strobe, 2)) |-> (b_out == $past(a_in)));

  assert_ab_qual_R4: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && !ab_oe_n && $past(!rst && !ab_le && ab_ce_n && !ab_oe_n))
      |-> $stable(b_out));

  assert_ab_fall_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(ab_le) && !ab_oe_n && $past(!rst && a_in_vld)) |-> (b_out == $past(a_in)));

  assert_b_drive_R6: assert property (@(posedge clk) disable iff (rst)
    ab_oe_n |-> (!b_out_vld && b_out == '0));

  assert_a_drive_R6: assert property (@(posedge clk) disable iff (rst)
    ba_oe_n |-> (!a_out_vld && a_out == '0));

  assert_a_en_R6: assert property (@(posedge clk) disable iff (rst)
    !ba_oe_n |-> a_out_vld);

  assert_ba_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (ba_le && b_in_vld && !ba_oe_n) |-> (a_out == b_in));

  generate
    if (HOLD_EN) begin : g_keep_chk
      assert_ab_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (ab_le && !ab_oe_n && !a_in_vld && $past(!rst && a_in_vld))
          |-> (b_out == $past(a_in)));
    end
  endgenerate
endmodule

bind regbus_xcvr xcvr_chk #(.WIDTH(WIDTH), .HOLD_EN(HOLD_EN)) u_chk (.*);

// File: tb/regbus_xcvr_tb.sv
`timescale 1ns/1ps
module regbus_xcvr_tb;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic a_in_vld = 1'b1, b_in_vld = 1'b1;
  logic ab_le = 0, ab_strobe = 0, ab_ce_n = 0, ab_oe_n = 0;
  logic ba_le = 0, ba_strobe = 0, ba_ce_n = 0, ba_oe_n = 0;
  logic [W-1:0] a_out, b_out;
  logic a_out_vld, b_out_vld;

  always #2.5 clk = ~clk;

  regbus_xcvr #(.WIDTH(W), .HOLD_EN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .a_in_vld(a_in_vld),
    .b_in(b_in), .b_in_vld(b_in_vld),
    .ab_le(ab_le), .ab_strobe(ab_strobe), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
    .ba_le(ba_le), .ba_strobe(ba_strobe), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n),
    .a_out(a_out), .a_out_vld(a_out_vld), .b_out(b_out), .b_out_vld(b_out_vld)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] ka = '0, kb = '0, sab = '0, sba = '0;
  logic pab = 0, pba = 0;

  task automatic cmp(input string tag, input string port, input logic [W-1:0] act,
                     input logic av, input logic [W-1:0] exp, input logic ev);
    n_cmp++;
    if (act !== exp || av !== ev) begin
      n_bad++;
      $display("FAIL %s port %s: actual data=%h vld=%b expected data=%h vld=%b",
               tag, port, act, av, exp, ev);
    end
  endtask

  task automatic tick(input string tag);
    logic [W-1:0] ea, eb, nsab, nsba;
    #1;
    ea = a_in_vld ? a_in : ka;
    eb = b_in_vld ? b_in : kb;
    cmp(tag, "B", b_out, b_out_vld, ab_oe_n ? '0 : (ab_le ? ea : sab), !ab_oe_n);
    cmp(tag, "A", a_out, a_out_vld, ba_oe_n ? '0 : (ba_le ? eb : sba), !ba_oe_n);
    nsab = sab; nsba = sba;
    if (ab_le || (ab_strobe && !pab && !ab_ce_n)) nsab = ea;
    if (ba_le || (ba_strobe && !pba && !ba_ce_n)) nsba = eb;
    @(posedge clk);
    if (a_in_vld) ka = a_in;
    if (b_in_vld) kb = b_in;
    sab = nsab; sba = nsba; pab = ab_strobe; pba = ba_strobe;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R9: cleared state visible through hold path
    tick("R9"); tick("R9");
    // R1: pass-through, several patterns
    ab_le = 1; ba_le = 1;
    a_in = 12'hA5C; b_in = 12'h3F1; tick("R1");
    a_in = 12'hFFF; b_in = 12'h000; tick("R1");
    a_in = 12'h800; b_in = 12'h001; tick("R1");
    // R5: pass enable falls, last pass value kept
    a_in = 12'h123; tick("R5");
    ab_le = 0; a_in = 12'h456; tick("R5"); tick("R5");
    // R2: hold with moving input
    a_in = 12'h777; tick("R2"); a_in = 12'h0F0; tick("R2");
    // R3: qualified rise captures once, held strobe does nothing more
    ab_strobe = 1; a_in = 12'hBEE; tick("R3");
    a_in = 12'hCAB; tick("R3"); tick("R3");
    ab_strobe = 0; tick("R3");
    ab_strobe = 1; tick("R3"); ab_strobe = 0; a_in = 12'h999; tick("R3");
    // R4: qualifier high blocks rises
    ab_ce_n = 1; ab_strobe = 1; a_in = 12'h5A5; tick("R4");
    ab_strobe = 0; tick("R4"); ab_strobe = 1; a_in = 12'hA5A; tick("R4");
    ab_strobe = 0; ab_ce_n = 0; tick("R4");
    // R6: drive enable off and back on
    ab_oe_n = 1; ba_oe_n = 1; tick("R6"); a_in = 12'h111; tick("R6");
    ab_oe_n = 0; ba_oe_n = 0; tick("R6");
    // R8: undriven inputs use the keeper
    ab_le = 1; a_in = 12'h6D2; tick("R8");
    a_in_vld = 0; a_in = 12'h000; tick("R8"); a_in = 12'hFFF; tick("R8");
    b_in = 12'h2E4; tick("R8"); b_in_vld = 0; b_in = 12'h0AA; tick("R8");
    ab_le = 0; ab_strobe = 1; tick("R8"); ab_strobe = 0; a_in_vld = 1; b_in_vld = 1; tick("R8");
    // R7: directions driven independently with opposing controls
    for (int i = 0; i < 600; i++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      a_in_vld = ($urandom % 4) != 0; b_in_vld = ($urandom % 4) != 0;
      ab_le = ($urandom % 3) == 0; ba_le = ($urandom % 3) == 1;
      ab_strobe = $urandom % 2; ba_strobe = $urandom % 2;
      ab_ce_n = ($urandom % 4) == 0; ba_ce_n = ($urandom % 4) == 1;
      ab_oe_n = ($urandom % 5) == 0; ba_oe_n = ($urandom % 5) == 1;
      tick("R7");
    end
    // R9: reset mid-run clears both stores and keepers
    ab_le = 0; ba_le = 0; ab_oe_n = 0; ba_oe_n = 0; ab_strobe = 0; ba_strobe = 0;
    rst = 1; @(posedge clk); @(negedge clk);
    ka = '0; kb = '0; sab = '0; sba = '0; pab = 0; pba = 0;
    rst = 0; tick("R9");
    ab_le = 1; a_in_vld = 0; ba_le = 1; b_in_vld = 0; tick("R9");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule